// File: doc/BRIEF.md
# Voltage and Frequency Domain Sequencer

This block holds the operating point of a many-tile die. Every frequency island has a clock-divider code that the block drives out. Every voltage domain has a supply level. The voltage level is requested from an external regulator through a request/acknowledge pair. Each of six tile domains covers four tiles and owns one frequency island per tile. A seventh domain supplies the network island. An eighth domain supplies three memory-controller islands.

A master core issues commands on a single command port. A supply command moves a whole domain one voltage level up or down. The block then sets every island in that domain to the highest frequency code the new level allows. The ordering keeps the clock inside the safe envelope at all times. When stepping up, the voltage is raised first and the frequency only after the regulator acknowledges. When stepping down, the frequency is lowered first and the voltage after.

A clock-only command moves one island's code by one step and completes in a single cycle. A supply change may take millions of cycles. During that time a per-domain busy flag stays high and new commands to that domain are refused. A pulse marks the end of the change.

Top module: `dvfs_ctrl`

## Requirements
- R1: After reset every domain is at voltage level 0, every island is at frequency code 1, no domain is busy, `reg_req` is low and every response output is low.
- R2: Islands 0 to 23 belong to domain (island / 4). Island 24 belongs to domain 6. Islands 25, 26 and 27 belong to domain 7.
- R3: The highest frequency code allowed at voltage level v is min(2v+1, 15). At no cycle does an island's code exceed this value for its domain's present level.
- R4: An accepted step-up command (`cmd_freq`=0, `cmd_up`=1) raises `reg_req` with `reg_dom` set to the domain and `reg_level` set to the old level plus one, while the domain's codes stay unchanged. After `reg_ack` the domain's level becomes the new value and all of its islands move to the cap for that level.
- R5: For an accepted step-down command (`cmd_up`=0), all islands of the domain are already at the cap for the lower level before `reg_req` rises, and the domain's level changes only on `reg_ack`.
- R6: A domain's `dom_busy` bit is high from the cycle after the command is accepted until the sequence ends. `seq_done` pulses for one cycle in the cycle in which the bit drops.
- R7: A supply command that arrives while any supply sequence runs, or a clock-only command to an island whose domain is busy, gets `resp_busy` and changes nothing.
- R8: An accepted clock-only command (`cmd_freq`=1) changes the code of island `cmd_isl` by one, in the direction of `cmd_up`, and gives `resp_ok`, both one cycle after the command.
- R9: A clock-only step up from the cap, a step down from code 0, or a step to an island number of 28 or more gets `resp_reject` and leaves the code as it was.
- R10: A supply step up from level 7, or a step down from level 0, gets `resp_reject` and starts no sequence.
- R11: While `reg_req` is high without `reg_ack`, it stays high on the next cycle with `reg_dom` and `reg_level` unchanged. An `reg_ack` with no request pending has no effect.
- R12: Clock-only commands to islands of a domain that is not busy are served during another domain's supply sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_freq | input | 1 | 1 = clock-only step, 0 = supply step |
| cmd_up | input | 1 | 1 = step up, 0 = step down |
| cmd_dom | input | 3 | Target domain of a supply step |
| cmd_isl | input | 5 | Target island of a clock-only step |
| resp_ok | output | 1 | Command accepted (one cycle after it) |
| resp_busy | output | 1 | Command refused, domain or sequencer busy |
| resp_reject | output | 1 | Command refused, out of range |
| reg_req | output | 1 | Regulator level change requested |
| reg_dom | output | 3 | Domain of the request |
| reg_level | output | 3 | Requested voltage level |
| reg_ack | input | 1 | Regulator has settled |
| dom_busy | output | 8 | Per-domain supply change in progress |
| seq_done | output | 1 | One-cycle pulse at the end of a supply change |
| v_level | output | 24 | Voltage level per domain, 3 bits each |
| f_level | output | 112 | Divider code per island, 4 bits each |

## Verification
Several properties are checked on every cycle:
- the frequency envelope against the present voltage of each island's domain;
- the one-level distance and stability of a pending regulator request;
- the refusal of supply commands during a sequence;
- the exclusivity of the three response flags.

Other behaviour can only be shown by the directed scenarios:
- the ordering of clock and supply changes in each direction;
- the island-to-domain grouping;
- the refusals at both ends of each range;
- the handling of clock-only commands to other domains while one domain waits on its regulator.

// File: rtl/dvfs_ctrl.sv
module dvfs_ctrl #(
  parameter int N_TILE_DOM    = 6,
  parameter int TILES_PER_DOM = 4,
  parameter int N_MC_ISL      = 3,
  parameter int VW            = 3,
  parameter int FW            = 4,
  parameter int F_AT_V0       = 1,
  parameter int F_PER_V       = 2,
  localparam int NT = N_TILE_DOM * TILES_PER_DOM,
  localparam int ND = N_TILE_DOM + 2,
  localparam int NI = NT + 1 + N_MC_ISL,
  localparam int DW = $clog2(ND),
  localparam int IW = $clog2(NI)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_freq,
  input  logic             cmd_up,
  input  logic [DW-1:0]    cmd_dom,
  input  logic [IW-1:0]    cmd_isl,
  output logic             resp_ok,
  output logic             resp_busy,
  output logic             resp_reject,
  output logic             reg_req,
  output logic [DW-1:0]    reg_dom,
  output logic [VW-1:0]    reg_level,
  input  logic             reg_ack,
  output logic [ND-1:0]    dom_busy,
  output logic             seq_done,
  output logic [ND*VW-1:0] v_level,
  output logic [NI*FW-1:0] f_level
);
  localparam int VMAX = (1 << VW) - 1;
  localparam int FTOP = (1 << FW) - 1;

  typedef enum logic [2:0] {IDLE, RAISE_V, WAIT_V, SET_F, LOWER_F, DONE} st_t;

  function automatic logic [FW-1:0] fmax(input logic [VW-1:0] v);
    int t;
    t = F_AT_V0 + F_PER_V * int'(v);
    if (t > FTOP) t = FTOP;
    return FW'(t);
  endfunction

  function automatic logic [DW-1:0] dom_of(input int i);
    if (i < NT) return DW'(i / TILES_PER_DOM);
    if (i == NT) return DW'(N_TILE_DOM);
    return DW'(N_TILE_DOM + 1);
  endfunction

  st_t           st;
  logic [DW-1:0] cur_dom;
  logic [VW-1:0] tgt_v;
  logic          going_up;
  logic [VW-1:0] v_q [ND];
  logic [FW-1:0] f_q [NI];

  wire           isl_ok = int'(cmd_isl) < NI;
  wire           dom_ok = int'(cmd_dom) < ND;
  wire [FW-1:0]  sel_f  = isl_ok ? f_q[cmd_isl] : '0;
  wire [DW-1:0]  isl_dom = dom_of(int'(cmd_isl));
  wire [VW-1:0]  sel_v  = dom_ok ? v_q[cmd_dom] : '0;
  wire [VW-1:0]  isl_v  = v_q[isl_dom];

  always_comb
    for (int d = 0; d < ND; d++) dom_busy[d] = (st != IDLE) && (cur_dom == DW'(d));

  assign reg_req   = (st == WAIT_V);
  assign reg_dom   = cur_dom;
  assign reg_level = tgt_v;

  for (genvar d = 0; d < ND; d++) begin : g_v
    assign v_level[d*VW +: VW] = v_q[d];
  end
  for (genvar i = 0; i < NI; i++) begin : g_f
    assign f_level[i*FW +: FW] = f_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      cur_dom <= '0;
      tgt_v <= '0;
      going_up <= 1'b0;
      resp_ok <= 1'b0;
      resp_busy <= 1'b0;
      resp_reject <= 1'b0;
      seq_done <= 1'b0;
      for (int d = 0; d < ND; d++) v_q[d] <= '0;
      for (int i = 0; i < NI; i++) f_q[i] <= fmax('0);
    end else begin
      resp_ok <= 1'b0;
      resp_busy <= 1'b0;
      resp_reject <= 1'b0;
      seq_done <= 1'b0;
      case (st)
        RAISE_V: st <= WAIT_V;
        WAIT_V: if (reg_ack) begin
          v_q[cur_dom] <= tgt_v;
          st <= going_up ? SET_F : DONE;
        end
        SET_F, LOWER_F: begin
          for (int i = 0; i < NI; i++)
            if (dom_of(i) == cur_dom) f_q[i] <= fmax(tgt_v);
          st <= (st == SET_F) ? DONE : RAISE_V;
        end
        DONE: begin
          st <= IDLE;
          seq_done <= 1'b1;
        end
        default: ;
      endcase
      if (cmd_valid) begin
        if (cmd_freq) begin
          if (!isl_ok) resp_reject <= 1'b1;
          else if (dom_busy[isl_dom]) resp_busy <= 1'b1;
          else if (cmd_up ? (sel_f >= fmax(isl_v)) : (sel_f == '0)) resp_reject <= 1'b1;
          else begin
            f_q[cmd_isl] <= cmd_up ? sel_f + 1'b1 : sel_f - 1'b1;
            resp_ok <= 1'b1;
          end
        end else begin
          if (st != IDLE) resp_busy <= 1'b1;
          else if (!dom_ok || (cmd_up ? (int'(sel_v) == VMAX) : (sel_v == '0)))
            resp_reject <= 1'b1;
          else begin
            cur_dom <= cmd_dom;
            tgt_v <= cmd_up ? sel_v + 1'b1 : sel_v - 1'b1;
            going_up <= cmd_up;
            st <= cmd_up ? RAISE_V : LOWER_F;
            resp_ok <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dvfs_ctrl_chk.sv
module dvfs_ctrl_chk #(
  parameter int N_TILE_DOM    = 6,
  parameter int TILES_PER_DOM = 4,
  parameter int N_MC_ISL      = 3,
  parameter int VW            = 3,
  parameter int FW            = 4,
  parameter int F_AT_V0       = 1,
  parameter int F_PER_V       = 2,
  localparam int NT = N_TILE_DOM * TILES_PER_DOM,
  localparam int ND = N_TILE_DOM + 2,
  localparam int NI = NT + 1 + N_MC_ISL,
  localparam int DW = $clog2(ND),
  localparam int IW = $clog2(NI)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_freq,
  input logic             cmd_up,
  input logic [DW-1:0]    cmd_dom,
  input logic [IW-1:0]    cmd_isl,
  input logic             resp_ok,
  input logic             resp_busy,
  input logic             resp_reject,
  input logic             reg_req,
  input logic [DW-1:0]    reg_dom,
  input logic [VW-1:0]    reg_level,
  input logic             reg_ack,
  input logic [ND-1:0]    dom_busy,
  input logic             seq_done,
  input logic [ND*VW-1:0] v_level,
  input logic [NI*FW-1:0] f_level
);
  localparam int FTOP = (1 << FW) - 1;

  function automatic int cap(input logic [VW-1:0] v);
    int t;
    t = F_AT_V0 + F_PER_V * int'(v);
    return (t > FTOP) ? FTOP : t;
  endfunction

  wire [VW-1:0] req_cur = v_level[int'(reg_dom)*VW +: VW];

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_dom) && $stable(reg_level));

  a_r4_one_level: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> (int'(reg_level) == int'(req_cur) + 1) || (int'(reg_level) + 1 == int'(req_cur)));

  a_r7_volt_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_freq && (|dom_busy) |=> resp_busy);

  a_r8_resp_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resp_ok, resp_busy, resp_reject}));

  a_r6_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dom_busy));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !(|dom_busy) && !reg_req);

  for (genvar i = 0; i < NI; i++) begin : g_cap
    localparam int D = (i < NT) ? i / TILES_PER_DOM : ((i == NT) ? N_TILE_DOM : N_TILE_DOM + 1);
    a_r3_envelope: assert property (@(posedge clk) disable iff (!rst_n)
      int'(f_level[i*FW +: FW]) <= cap(v_level[D*VW +: VW]));
  end
endmodule

bind dvfs_ctrl dvfs_ctrl_chk #(
  .N_TILE_DOM(N_TILE_DOM), .TILES_PER_DOM(TILES_PER_DOM), .N_MC_ISL(N_MC_ISL),
  .VW(VW), .FW(FW), .F_AT_V0(F_AT_V0), .F_PER_V(F_PER_V)
) u_chk (.*);

// File: tb/tb_dvfs_ctrl.sv
module tb_dvfs_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_freq = 1'b0, cmd_up = 1'b0, reg_ack = 1'b0;
  logic [2:0] cmd_dom = '0;
  logic [4:0] cmd_isl = '0;
  logic resp_ok, resp_busy, resp_reject, reg_req, seq_done;
  logic [2:0] reg_dom, reg_level;
  logic [7:0] dom_busy;
  logic [23:0] v_level;
  logic [111:0] f_level;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  dvfs_ctrl dut (.*);

  function automatic int vl(input int d); return int'(v_level[d*3 +: 3]); endfunction
  function automatic int fl(input int i); return int'(f_level[i*4 +: 4]); endfunction
  function automatic int bdom(input int i); return (i < 24) ? i / 4 : ((i == 24) ? 6 : 7); endfunction
  function automatic int bcap(input int v); return (2*v+1 > 15) ? 15 : 2*v+1; endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // drive one command; returns 0 ok, 1 busy, 2 reject
  task automatic send(input bit fr, input bit up, input int d, input int isl, output int r);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_freq = fr; cmd_up = up; cmd_dom = 3'(d); cmd_isl = 5'(isl);
    @(negedge clk);
    cmd_valid = 1'b0;
    r = resp_ok ? 0 : resp_busy ? 1 : resp_reject ? 2 : 3;
  endtask

  task automatic vstep(input int d, input bit up, input int hold, input bit mid);
    int r, v0, f0, fi;
    int isl[$];
    for (int i = 0; i < 28; i++) if (bdom(i) == d) isl.push_back(i);
    v0 = vl(d); f0 = fl(isl[0]);
    send(1'b0, up, d, 0, r);
    check("R4 supply step accepted", r, 0);
    check("R6 busy during sequence", int'(dom_busy[d]), 1);
    while (!reg_req) @(negedge clk);
    check("R4 request domain", int'(reg_dom), d);
    check("R4 request level", int'(reg_level), up ? v0 + 1 : v0 - 1);
    if (up) check("R4 clock held before ack", fl(isl[0]), f0);
    else begin
      check("R5 clock lowered before request", fl(isl[0]), bcap(v0 - 1));
      check("R5 level held before ack", vl(d), v0);
    end
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R11 request held", int'(reg_req), 1);
      check("R11 level stable", int'(reg_level), up ? v0 + 1 : v0 - 1);
    end
    if (mid) begin
      send(1'b1, 1'b0, 0, 5, r);
      check("R7 clock step to busy domain", r, 1);
      check("R7 busy leaves code", fl(5), f0);
      send(1'b0, 1'b1, 2, 0, r);
      check("R7 supply step while sequencing", r, 1);
      check("R7 refused supply leaves level", vl(2), 0);
      fi = fl(0);
      send(1'b1, 1'b0, 0, 0, r);
      check("R12 other domain served", r, 0);
      check("R12 other domain code", fl(0), fi - 1);
    end
    @(negedge clk); reg_ack = 1'b1;
    @(negedge clk); reg_ack = 1'b0;
    while (dom_busy[d]) @(negedge clk);
    check("R6 done pulse", int'(seq_done), 1);
    check(up ? "R4 level after ack" : "R5 level after ack", vl(d), up ? v0 + 1 : v0 - 1);
    foreach (isl[j])
      check(up ? "R4 islands at cap" : "R5 islands at cap", fl(isl[j]), bcap(up ? v0 + 1 : v0 - 1));
  endtask

  task automatic t_reset;
    for (int d = 0; d < 8; d++) check("R1 reset level", vl(d), 0);
    for (int i = 0; i < 28; i++) check("R1 reset code", fl(i), 1);
    check("R1 reset busy", int'(dom_busy), 0);
    check("R1 reset request", int'(reg_req), 0);
    check("R1 reset responses", int'({resp_ok, resp_busy, resp_reject, seq_done}), 0);
  endtask

  task automatic t_freq_only;
    int r;
    send(1'b1, 1'b0, 0, 9, r);
    check("R8 step down ok", r, 0);
    check("R8 step down code", fl(9), 0);
    send(1'b1, 1'b0, 0, 9, r);
    check("R9 below zero rejected", r, 2);
    check("R9 code held at zero", fl(9), 0);
    send(1'b1, 1'b1, 0, 9, r);
    check("R8 step up code", fl(9), 1);
    send(1'b1, 1'b1, 0, 9, r);
    check("R9 above cap rejected", r, 2);
    check("R3 code held at cap", fl(9), 1);
    send(1'b1, 1'b1, 0, 30, r);
    check("R9 bad island rejected", r, 2);
  endtask

  task automatic t_up_down;
    vstep(1, 1'b1, 0, 1'b1);
    check("R2 neighbour tile domain untouched", fl(8), 1);
    check("R2 neighbour below untouched", fl(3), 1);
    vstep(1, 1'b1, 0, 1'b0);
    vstep(1, 1'b0, 3, 1'b0);
  endtask

  task automatic t_limits;
    int r;
    send(1'b0, 1'b0, 3, 0, r);
    check("R10 down from zero rejected", r, 2);
    check("R10 no sequence", int'(dom_busy), 0);
    for (int k = 0; k < 7; k++) vstep(6, 1'b1, 0, 1'b0);
    check("R3 network island top code", fl(24), 15);
    check("R2 memory islands untouched", fl(25), 1);
    send(1'b0, 1'b1, 6, 0, r);
    check("R10 up from top rejected", r, 2);
    check("R10 top level held", vl(6), 7);
    send(1'b1, 1'b1, 0, 24, r);
    check("R9 clock above top cap rejected", r, 2);
    vstep(7, 1'b1, 2, 1'b0);
    check("R2 memory island 27 follows domain 7", fl(27), 3);
  endtask

  task automatic t_stray_ack;
    @(negedge clk); reg_ack = 1'b1;
    @(negedge clk); reg_ack = 1'b0;
    @(negedge clk);
    check("R11 stray ack no request", int'(reg_req), 0);
    check("R11 stray ack leaves level", vl(7), 1);
    check("R11 stray ack leaves busy", int'(dom_busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_freq_only();
    t_up_down();
    t_limits();
    t_stray_ack();
    summary();
  end
endmodule